// File: doc/BRIEF.md
# Interrupt Control and State Register

This block is the composite control/state word of a nested vectored interrupt controller. It sits next to the array that tracks the pending and active state of system exceptions and external interrupt lines. It does not arbitrate priority. The highest pending vector comes from outside, and so do the active vector and the return-to-base indication. On a read it packs those inputs, a summary of the external pending lines and the pending flags of three system exceptions into one 32-bit word. The three exceptions are the non-maskable interrupt, the deferred service request and the system tick.

On a write it decodes the set-pending and clear-pending command bits into one-cycle strobes toward the tracking array. The non-maskable interrupt can only be set. The deferred service request and the system tick each have a set bit and a clear bit, and both may arrive in the same write. When they do, the set bit takes priority and the clear bit is dropped. The read word is combinational from the inputs. The strobes are registered, so they appear in the cycle after the write and last exactly one cycle.

Top module: `icsr_ctrl`

## Requirements
- R1: Read bits 8:0 carry the active vector number when an exception is active (act_valid=1), and read as zero when nothing is active.
- R2: Read bit 11 is 1 when no exception is active, or when the active exception has no preempted exception beneath it (act_ret_base=1); otherwise it is 0.
- R3: Read bits 20:12 carry the highest pending vector number when pend_valid=1, and read as zero when nothing is pending.
- R4: Read bit 22 is 1 exactly when at least one external line is pending. External line i is vector 16+i. The system-exception pending flags do not affect bit 22.
- R5: Read bit 26 equals sys_pend[0] (system tick), bit 28 equals sys_pend[1] (deferred service), and bit 31 equals sys_pend[2] (non-maskable). Bits 9, 10, 21, 23-25, 27, 29 and 30 read as 0.
- R6: A write with bit 31 set raises set_pend[2] (non-maskable set) for exactly the one cycle after the write. No clear strobe exists for it.
- R7: A write with bit 28 set raises set_pend[1] in the next cycle. A write with bit 27 set and bit 28 clear raises clr_pend[1] in the next cycle. When both bits are set, only the set strobe is raised.
- R8: A write with bit 26 set raises set_pend[0] in the next cycle. A write with bit 25 set and bit 26 clear raises clr_pend[0] in the next cycle. When both bits are set, only the set strobe is raised.
- R9: After reset all strobes are 0. A cycle with no write, or a write whose bits 31 and 28-25 are all zero, raises no strobe, whatever the other data bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| act_valid | input | 1 | An exception is active |
| act_vec | input | 9 | Active vector number |
| act_ret_base | input | 1 | Active exception has nothing preempted beneath it |
| pend_valid | input | 1 | Some exception is pending |
| pend_vec | input | 9 | Highest pending vector number |
| ext_pend | input | NUM_EXT | Pending flags of external lines (line i = vector 16+i) |
| sys_pend | input | 3 | Pending flags: [0] system tick, [1] deferred service, [2] non-maskable |
| rd_data | output | 32 | Assembled read word |
| set_pend | output | 3 | Set-pending strobes, same bit order as sys_pend |
| clr_pend | output | 2 | Clear-pending strobes: [0] system tick, [1] deferred service |

## Verification
The hardest case to reach is a write that carries a set bit and the matching clear bit together. Real software seldom issues one, yet that write alone shows whether the set bit takes priority. The stimulus writes that word directly and also sends a lone clear and a combined clear of both exceptions. It writes a word with every non-command bit set, to show that those bits cannot raise a strobe. On the read side, a vector table combines a pending system tick with no external line pending, so a leak of system pending flags into the external summary bit would show.

// File: rtl/icsr_pkg.sv
package icsr_pkg;
  localparam int VEC_W      = 9;
  localparam int ACT_LSB    = 0;
  localparam int RETB_BIT   = 11;
  localparam int PEND_LSB   = 12;
  localparam int EXTP_BIT   = 22;
  localparam int TICK_BIT   = 26;
  localparam int TICK_CLR   = 25;
  localparam int DSR_BIT    = 28;
  localparam int DSR_CLR    = 27;
  localparam int NMI_BIT    = 31;
  localparam int N_SET      = 3;
  localparam int N_CLR      = 2;

  typedef enum logic [1:0] {
    SRC_TICK = 2'd0,
    SRC_DSR  = 2'd1,
    SRC_NMI  = 2'd2
  } sys_src_e;

  // Vector field: shows the number only when the qualifier is set.
  function automatic logic [VEC_W-1:0] qual_vec(input logic vld, input logic [VEC_W-1:0] v);
    return vld ? v : '0;
  endfunction

  // Set beats clear when both command bits are present.
  function automatic logic clr_only(input logic set_b, input logic clr_b);
    return clr_b & ~set_b;
  endfunction
endpackage

// File: rtl/icsr_read_pack.sv
module icsr_read_pack
  import icsr_pkg::*;
#(
  parameter int NUM_EXT = 64
) (
  input  logic               act_valid,
  input  logic [VEC_W-1:0]   act_vec,
  input  logic               act_ret_base,
  input  logic               pend_valid,
  input  logic [VEC_W-1:0]   pend_vec,
  input  logic [NUM_EXT-1:0] ext_pend,
  input  logic [N_SET-1:0]   sys_pend,
  output logic [31:0]        word
);
  logic ext_any;
  assign ext_any = |ext_pend;

  always_comb begin
    word = '0;
    word[ACT_LSB +: VEC_W]  = qual_vec(act_valid, act_vec);
    word[RETB_BIT]          = ~act_valid | act_ret_base;
    word[PEND_LSB +: VEC_W] = qual_vec(pend_valid, pend_vec);
    word[EXTP_BIT]          = ext_any;
    word[TICK_BIT]          = sys_pend[SRC_TICK];
    word[DSR_BIT]           = sys_pend[SRC_DSR];
    word[NMI_BIT]           = sys_pend[SRC_NMI];
  end
endmodule

// File: rtl/icsr_write_decode.sv
module icsr_write_decode
  import icsr_pkg::*;
(
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [N_SET-1:0] set_req,
  output logic [N_CLR-1:0] clr_req
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[30:29], wr_data[24:0]};

  always_comb begin
    set_req = '0;
    clr_req = '0;
    if (wr_en) begin
      set_req[SRC_TICK] = wr_data[TICK_BIT];
      set_req[SRC_DSR]  = wr_data[DSR_BIT];
      set_req[SRC_NMI]  = wr_data[NMI_BIT];
      clr_req[SRC_TICK] = clr_only(wr_data[TICK_BIT], wr_data[TICK_CLR]);
      clr_req[SRC_DSR]  = clr_only(wr_data[DSR_BIT],  wr_data[DSR_CLR]);
    end
  end
endmodule

// File: rtl/icsr_strobe_reg.sv
module icsr_strobe_reg #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/icsr_ctrl.sv
module icsr_ctrl
  import icsr_pkg::*;
#(
  parameter int NUM_EXT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic               act_valid,
  input  logic [VEC_W-1:0]   act_vec,
  input  logic               act_ret_base,
  input  logic               pend_valid,
  input  logic [VEC_W-1:0]   pend_vec,
  input  logic [NUM_EXT-1:0] ext_pend,
  input  logic [N_SET-1:0]   sys_pend,
  output logic [31:0]        rd_data,
  output logic [N_SET-1:0]   set_pend,
  output logic [N_CLR-1:0]   clr_pend
);
  logic [N_SET-1:0] set_req;
  logic [N_CLR-1:0] clr_req;

  icsr_read_pack #(.NUM_EXT(NUM_EXT)) u_read (
    .act_valid    (act_valid),
    .act_vec      (act_vec),
    .act_ret_base (act_ret_base),
    .pend_valid   (pend_valid),
    .pend_vec     (pend_vec),
    .ext_pend     (ext_pend),
    .sys_pend     (sys_pend),
    .word         (rd_data)
  );

  icsr_write_decode u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .set_req (set_req),
    .clr_req (clr_req)
  );

  icsr_strobe_reg #(.WIDTH(N_SET + N_CLR)) u_stb (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({clr_req, set_req}),
    .q     ({clr_pend, set_pend})
  );
endmodule

// File: rtl/icsr_ctrl_chk.sv
module icsr_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        act_valid,
  input logic        pend_valid,
  input logic [31:0] rd_data,
  input logic [2:0]  set_pend,
  input logic [1:0]  clr_pend
);
  AST_ACT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !act_valid |-> rd_data[8:0] == 9'd0); // R1
  AST_RET_BASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !act_valid |-> rd_data[11]); // R2
  AST_PEND_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !pend_valid |-> rd_data[20:12] == 9'd0); // R3
  AST_NMI_SET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_data[31]) |=> set_pend[2]); // R6
  AST_DSR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_data[28]) |=> (set_pend[1] && !clr_pend[1])); // R7
  AST_TICK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_data[26]) |=> (set_pend[0] && !clr_pend[0])); // R8
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> (set_pend == 3'b000 && clr_pend == 2'b00)); // R9
endmodule

bind icsr_ctrl icsr_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .act_valid  (act_valid),
  .pend_valid (pend_valid),
  .rd_data    (rd_data),
  .set_pend   (set_pend),
  .clr_pend   (clr_pend)
);

// File: tb/icsr_ctrl_bench.sv
`timescale 1ns/1ps
module icsr_ctrl_bench;
  localparam int NEXT = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic act_valid = 1'b0;
  logic [8:0] act_vec = '0;
  logic act_ret_base = 1'b0;
  logic pend_valid = 1'b0;
  logic [8:0] pend_vec = '0;
  logic [NEXT-1:0] ext_pend = '0;
  logic [2:0] sys_pend = '0;
  logic [31:0] rd_data;
  logic [2:0] set_pend;
  logic [1:0] clr_pend;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  icsr_ctrl #(.NUM_EXT(NEXT)) u_icsr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .act_valid(act_valid), .act_vec(act_vec), .act_ret_base(act_ret_base),
    .pend_valid(pend_valid), .pend_vec(pend_vec), .ext_pend(ext_pend),
    .sys_pend(sys_pend), .rd_data(rd_data), .set_pend(set_pend), .clr_pend(clr_pend)
  );

  // av, avec, ret, pv, pvec, ext line (127 = none), sys, expected word
  typedef struct packed {
    logic        av;
    logic [8:0]  avec;
    logic        ret;
    logic        pv;
    logic [8:0]  pvec;
    logic [6:0]  ext;
    logic [2:0]  sys;
    logic [31:0] exp;
  } rvec_t;

  localparam rvec_t RTAB [6] = '{
    '{1'b0, 9'd0,   1'b0, 1'b0, 9'd0,   7'd127, 3'b000, 32'h0000_0800},
    '{1'b1, 9'd3,   1'b1, 1'b1, 9'd15,  7'd127, 3'b000, 32'h0000_F803},
    '{1'b1, 9'h03F, 1'b0, 1'b1, 9'h1FF, 7'd63,  3'b111, 32'h945F_F03F},
    '{1'b1, 9'd2,   1'b0, 1'b0, 9'h055, 7'd0,   3'b010, 32'h1040_0002},
    '{1'b0, 9'h1AA, 1'b1, 1'b1, 9'h010, 7'd127, 3'b001, 32'h0401_0800},
    '{1'b1, 9'h100, 1'b1, 1'b1, 9'd0,   7'd127, 3'b100, 32'h8000_0900}
  };

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_stb(input string req, input logic [2:0] es, input logic [1:0] ec);
    checks++;
    if (set_pend !== es || clr_pend !== ec) begin
      errors++;
      $display("FAIL %s actual set=%b clr=%b expected set=%b clr=%b",
               req, set_pend, clr_pend, es, ec);
    end
  endtask

  // Write at a falling edge; strobes are valid one falling edge later,
  // and must be gone one more falling edge later.
  task automatic do_write(input string req, input logic [31:0] d,
                          input logic [2:0] es, input logic [1:0] ec);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    #1 chk_stb(req, es, ec);
    @(negedge clk);
    #1 chk_stb({req, " one-cycle R9"}, 3'b000, 2'b00);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state (R9) and idle read (R1, R2)
    #5;
    chk_stb("R9 strobes in reset", 3'b000, 2'b00);
    chk32("R1 R2 idle word in reset", rd_data, 32'h0000_0800);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk_stb("R9 strobes after reset", 3'b000, 2'b00);

    // Read table: R1 R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      act_valid    = RTAB[i].av;
      act_vec      = RTAB[i].avec;
      act_ret_base = RTAB[i].ret;
      pend_valid   = RTAB[i].pv;
      pend_vec     = RTAB[i].pvec;
      ext_pend     = (RTAB[i].ext < 7'd64) ? (64'd1 << RTAB[i].ext) : '0;
      sys_pend     = RTAB[i].sys;
      #1 chk32($sformatf("R1 R2 R3 R4 R5 read vector %0d", i), rd_data, RTAB[i].exp);
    end

    // R2: active with a preempted exception beneath clears bit 11
    @(negedge clk);
    act_valid = 1'b1; act_vec = 9'd20; act_ret_base = 1'b0;
    pend_valid = 1'b0; ext_pend = '0; sys_pend = 3'b000;
    #1 chk32("R2 nested active", rd_data, 32'h0000_0014);
    // R4: system tick pending alone must not raise bit 22; all ext lines do
    sys_pend = 3'b001;
    #1 chk32("R4 system pend excluded", {31'd0, rd_data[22]}, 32'd0);
    ext_pend = '1;
    #1 chk32("R4 all ext lines", {31'd0, rd_data[22]}, 32'd1);
    ext_pend = '0;

    // Writes: R6 R7 R8 R9
    do_write("R6 nmi set",            32'h8000_0000, 3'b100, 2'b00);
    do_write("R7 dsr set",            32'h1000_0000, 3'b010, 2'b00);
    do_write("R7 dsr set beats clear",32'h1800_0000, 3'b010, 2'b00);
    do_write("R7 dsr clear",          32'h0800_0000, 3'b000, 2'b10);
    do_write("R8 tick set beats clear",32'h0600_0000,3'b001, 2'b00);
    do_write("R8 tick clear",         32'h0200_0000, 3'b000, 2'b01);
    do_write("R7 R8 both clears",     32'h0A00_0000, 3'b000, 2'b11);
    do_write("R6 R7 R8 all sets",     32'h9400_0000, 3'b111, 2'b00);
    do_write("R9 zero write",         32'h0000_0000, 3'b000, 2'b00);
    do_write("R9 non-command bits",   32'h61FF_FFFF, 3'b000, 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule